// File: doc/BRIEF.md
# Serial Port FIFO Interrupt Generator

This block sits between the data path of a synchronous serial port and the system interrupt controller. It holds an 8-entry transmit FIFO, filled by software and drained by the serial shifter, and an 8-entry receive FIFO, filled by completed frames from the receive shifter and drained by software. From the occupancy of the two queues and from overrun events it derives three individually maskable active-high requests and one combined request.

The two data-flow requests follow the FIFO occupancy as levels, so a DMA engine or a driver can move data purely on fill thresholds. The overrun request is a sticky status condition that software clears explicitly. The transmit request does not depend on the port enable, so the transmit queue can be preloaded before the port is switched on. Raw and masked status vectors expose every source for polling.

Top module: `sio_irq_unit`

## Requirements
- R1: Each FIFO returns entries in write order on `*_rdata` (first word visible without a pop), reports its occupancy on `*_count` one cycle after a push or pop, ignores a push while full and a pop while empty, and raises `*_full` at 8 entries and `*_empty` at 0.
- R2: A push and a pop in the same cycle leave the count unchanged when the FIFO is neither empty nor full and also when it is full (both are accepted); when the FIFO is empty the push is accepted and the pop ignored.
- R3: Raw status bit 0 is 1 whenever the receive FIFO holds 4 or more entries; `irq_rx` equals that bit AND `mask_rx` AND `port_en`.
- R4: Raw status bit 1 is 1 whenever the transmit FIFO holds 4 or fewer entries; `irq_tx` equals that bit AND `mask_tx`, independent of `port_en`.
- R5: A frame strobe while `port_en` is 1, the receive FIFO is full and `rx_rd` is 0 is an overrun: the frame is discarded, the FIFO contents and count are unchanged, and raw status bit 2 is 1 from the next cycle on.
- R6: Raw status bit 2 stays set until a cycle with `ovr_clr` at 1 clears it for the next cycle; a new overrun in the same cycle as the clear leaves it set.
- R7: Frame strobes while `port_en` is 0 are ignored: no push and no overrun.
- R8: `irq_ovr` equals raw status bit 2 AND `mask_ovr` AND `port_en`.
- R9: `stat_msk` carries `{irq_ovr, irq_tx, irq_rx}` in bits 2..0, and `irq_any` is 1 exactly when any of the three is 1.
- R10: After reset both FIFOs are empty, the overrun flag is clear, and with all masks at 0 every interrupt output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Serial port enable |
| mask_rx | input | 1 | Enable for the receive service request |
| mask_tx | input | 1 | Enable for the transmit service request |
| mask_ovr | input | 1 | Enable for the overrun request |
| ovr_clr | input | 1 | Write-one strobe clearing the overrun flag |
| tx_wr | input | 1 | Software write into the transmit FIFO |
| tx_wdata | input | DATA_W | Transmit write data |
| tx_rd | input | 1 | Shifter fetch from the transmit FIFO |
| tx_rdata | output | DATA_W | Oldest transmit entry |
| tx_count | output | CW | Transmit occupancy |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_frame | input | 1 | Frame-complete strobe from the receive shifter |
| rx_frame_data | input | DATA_W | Received frame |
| rx_rd | input | 1 | Software read from the receive FIFO |
| rx_rdata | output | DATA_W | Oldest receive entry |
| rx_count | output | CW | Receive occupancy |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| stat_raw | output | 3 | Unmasked sources: bit0 rx, bit1 tx, bit2 overrun |
| stat_msk | output | 3 | Masked sources, same bit order |
| irq_rx | output | 1 | Receive service request |
| irq_tx | output | 1 | Transmit service request |
| irq_ovr | output | 1 | Receive overrun request |
| irq_any | output | 1 | Combined request |

## Verification
The bench walks both FIFOs through every occupancy from 0 to 8 and back, and at each level tries all eight mask combinations with the port enabled and disabled, so an off-by-one threshold (asserting at 3 or 5 entries) or a transmit request wrongly gated by the enable shows up as a mismatch at a single level. It pushes into full and pops from empty FIFOs, where a missing guard would wrap the count or corrupt the order, and it issues simultaneous push and pop at empty, middle and full levels, where a design that blocks the push when full would lose a word. It sets overrun against a clear in the same cycle, where a clear-priority flag would drop the event, and sends frames with the port disabled, where a design that ignored the enable would fill the FIFO.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

    localparam int SRC_RX  = 0;
    localparam int SRC_TX  = 1;
    localparam int SRC_OVR = 2;
    localparam int NSRC    = 3;

    typedef struct packed {
        logic ovr;
        logic tx;
        logic rx;
    } src_vec_t;

endpackage

// File: rtl/sio_fifo.sv
module sio_fifo #(
    parameter  int DATA_W = 8,
    parameter  int DEPTH  = 8,
    localparam int PW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic [CW-1:0]     count,
    output logic              full,
    output logic              empty
);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PW-1:0]                wp;
        logic [PW-1:0]                rp;
        logic [CW-1:0]                cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic     take, give;
    logic [PW-1:0] wp_inc, rp_inc;

    // pointer advance: natural wrap for powers of two, compare otherwise
    generate
        if ((1 << PW) == DEPTH) begin : g_pow2
            assign wp_inc = q.wp + PW'(1);
            assign rp_inc = q.rp + PW'(1);
        end else begin : g_wrap
            assign wp_inc = (q.wp == PW'(DEPTH - 1)) ? '0 : q.wp + PW'(1);
            assign rp_inc = (q.rp == PW'(DEPTH - 1)) ? '0 : q.rp + PW'(1);
        end
    endgenerate

    always_comb begin
        d    = q;
        give = pop && (q.cnt != '0);
        take = push && ((q.cnt != CW'(DEPTH)) || give);
        if (take) begin
            d.mem[q.wp] = wdata;
            d.wp        = wp_inc;
        end
        if (give) begin
            d.rp = rp_inc;
        end
        unique case ({take, give})
            2'b10:   d.cnt = q.cnt + CW'(1);
            2'b01:   d.cnt = q.cnt - CW'(1);
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rdata = q.mem[q.rp];
    assign count = q.cnt;
    assign full  = (q.cnt == CW'(DEPTH));
    assign empty = (q.cnt == '0);

endmodule

// File: rtl/sio_irq_gen.sv
module sio_irq_gen
    import sio_irq_pkg::*;
#(
    parameter  int DEPTH    = 8,
    parameter  int RX_LEVEL = 4,
    parameter  int TX_ROOM  = 4,
    localparam int CW       = $clog2(DEPTH + 1),
    localparam int TX_LIMIT = DEPTH - TX_ROOM
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          port_en,
    input  logic          mask_rx,
    input  logic          mask_tx,
    input  logic          mask_ovr,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] tx_count,
    input  logic          ovr_event,
    input  logic          ovr_clr,
    output src_vec_t      raw,
    output src_vec_t      msk,
    output logic          any
);

    typedef struct packed {
        logic ovr;
    } gen_st_t;

    gen_st_t q, d;

    always_comb begin
        d     = q;
        // set has priority over the write-one clear
        d.ovr = ovr_event || (q.ovr && !ovr_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        raw.rx  = (rx_count >= CW'(RX_LEVEL));
        raw.tx  = (tx_count <= CW'(TX_LIMIT));
        raw.ovr = q.ovr;
        msk.rx  = raw.rx  && mask_rx  && port_en;
        msk.tx  = raw.tx  && mask_tx;
        msk.ovr = raw.ovr && mask_ovr && port_en;
        any     = |msk;
    end

endmodule

// File: rtl/sio_irq_unit.sv
module sio_irq_unit
    import sio_irq_pkg::*;
#(
    parameter  int DATA_W   = 8,
    parameter  int DEPTH    = 8,
    parameter  int RX_LEVEL = 4,
    parameter  int TX_ROOM  = 4,
    localparam int CW       = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic              mask_rx,
    input  logic              mask_tx,
    input  logic              mask_ovr,
    input  logic              ovr_clr,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              tx_rd,
    output logic [DATA_W-1:0] tx_rdata,
    output logic [CW-1:0]     tx_count,
    output logic              tx_full,
    output logic              tx_empty,
    input  logic              rx_frame,
    input  logic [DATA_W-1:0] rx_frame_data,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_rdata,
    output logic [CW-1:0]     rx_count,
    output logic              rx_full,
    output logic              rx_empty,
    output logic [NSRC-1:0]   stat_raw,
    output logic [NSRC-1:0]   stat_msk,
    output logic              irq_rx,
    output logic              irq_tx,
    output logic              irq_ovr,
    output logic              irq_any
);

    logic     rx_push;
    logic     ovr_event;
    src_vec_t raw_v, msk_v;

    assign rx_push   = port_en && rx_frame;
    assign ovr_event = rx_push && rx_full && !rx_rd;

    sio_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tx_wr),
        .wdata (tx_wdata),
        .pop   (tx_rd),
        .rdata (tx_rdata),
        .count (tx_count),
        .full  (tx_full),
        .empty (tx_empty)
    );

    sio_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .wdata (rx_frame_data),
        .pop   (rx_rd),
        .rdata (rx_rdata),
        .count (rx_count),
        .full  (rx_full),
        .empty (rx_empty)
    );

    sio_irq_gen #(.DEPTH(DEPTH), .RX_LEVEL(RX_LEVEL), .TX_ROOM(TX_ROOM)) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_en   (port_en),
        .mask_rx   (mask_rx),
        .mask_tx   (mask_tx),
        .mask_ovr  (mask_ovr),
        .rx_count  (rx_count),
        .tx_count  (tx_count),
        .ovr_event (ovr_event),
        .ovr_clr   (ovr_clr),
        .raw       (raw_v),
        .msk       (msk_v),
        .any       (irq_any)
    );

    assign stat_raw = raw_v;
    assign stat_msk = msk_v;
    assign irq_rx   = msk_v.rx;
    assign irq_tx   = msk_v.tx;
    assign irq_ovr  = msk_v.ovr;

endmodule

// File: rtl/sio_irq_chk.sv
module sio_irq_chk #(
    parameter  int DATA_W   = 8,
    parameter  int DEPTH    = 8,
    parameter  int RX_LEVEL = 4,
    parameter  int TX_ROOM  = 4,
    localparam int CW       = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              port_en,
    input logic              mask_rx,
    input logic              mask_tx,
    input logic              mask_ovr,
    input logic              ovr_clr,
    input logic              tx_wr,
    input logic [DATA_W-1:0] tx_wdata,
    input logic              tx_rd,
    input logic [DATA_W-1:0] tx_rdata,
    input logic [CW-1:0]     tx_count,
    input logic              tx_full,
    input logic              tx_empty,
    input logic              rx_frame,
    input logic [DATA_W-1:0] rx_frame_data,
    input logic              rx_rd,
    input logic [DATA_W-1:0] rx_rdata,
    input logic [CW-1:0]     rx_count,
    input logic              rx_full,
    input logic              rx_empty,
    input logic [2:0]        stat_raw,
    input logic [2:0]        stat_msk,
    input logic              irq_rx,
    input logic              irq_tx,
    input logic              irq_ovr,
    input logic              irq_any
);

    logic overrun_now;
    assign overrun_now = port_en && rx_frame && rx_full && !rx_rd;

    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count <= CW'(DEPTH)) && (tx_count <= CW'(DEPTH)));

    assert_pop_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && tx_rd && !tx_wr) |=> tx_empty);

    assert_push_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && tx_rd && !tx_empty) |=> $stable(tx_count));

    assert_rx_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx == (mask_rx && port_en && (rx_count >= CW'(RX_LEVEL))));

    assert_tx_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx == (mask_tx && (tx_count <= CW'(DEPTH - TX_ROOM))));

    assert_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_now |=> (rx_full && stat_raw[2]));

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_raw[2] && !ovr_clr) |=> stat_raw[2]);

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_clr && !overrun_now) |=> !stat_raw[2]);

    assert_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_en && !rx_rd) |=> $stable(rx_count));

    assert_ovr_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_en || !mask_ovr) |-> !irq_ovr);

    assert_all_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_rx && !mask_tx && !mask_ovr) |-> (!irq_any && (stat_msk == 3'b000)));

endmodule

bind sio_irq_unit sio_irq_chk #(
    .DATA_W   (DATA_W),
    .DEPTH    (DEPTH),
    .RX_LEVEL (RX_LEVEL),
    .TX_ROOM  (TX_ROOM)
) u_chk (.*);

// File: tb/sim_sio_irq_unit.sv
`timescale 1ns/1ps
module sim_sio_irq_unit;

    localparam int DW = 8;
    localparam int DEPTH = 8;
    localparam int CW = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic port_en = 1'b0, mask_rx = 1'b0, mask_tx = 1'b0, mask_ovr = 1'b0, ovr_clr = 1'b0;
    logic tx_wr = 1'b0, tx_rd = 1'b0, rx_frame = 1'b0, rx_rd = 1'b0;
    logic [DW-1:0] tx_wdata = '0, rx_frame_data = '0;
    logic [DW-1:0] tx_rdata, rx_rdata;
    logic [CW-1:0] tx_count, rx_count;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic [2:0] stat_raw, stat_msk;
    logic irq_rx, irq_tx, irq_ovr, irq_any;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int etx_q[$];
    int erx_q[$];
    bit eovr = 0;
    int seed = 17;

    always #2 clk = ~clk;

    sio_irq_unit #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (.*);

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic check_all(input string w);
        int rr, rt, mr, mt, mo;
        rr = (erx_q.size() >= 4);
        rt = (etx_q.size() <= 4);
        mr = rr & mask_rx & port_en;
        mt = rt & mask_tx;
        mo = int'(eovr) & mask_ovr & port_en;
        chk({"R1 tx_count ", w}, int'(tx_count), etx_q.size());
        chk({"R1 rx_count ", w}, int'(rx_count), erx_q.size());
        chk({"R1 tx_full ", w}, int'(tx_full), int'(etx_q.size() == DEPTH));
        chk({"R1 tx_empty ", w}, int'(tx_empty), int'(etx_q.size() == 0));
        chk({"R1 rx_full ", w}, int'(rx_full), int'(erx_q.size() == DEPTH));
        chk({"R1 rx_empty ", w}, int'(rx_empty), int'(erx_q.size() == 0));
        chk({"R3 raw rx ", w}, int'(stat_raw[0]), rr);
        chk({"R4 raw tx ", w}, int'(stat_raw[1]), rt);
        chk({"R5 raw ovr ", w}, int'(stat_raw[2]), int'(eovr));
        chk({"R3 irq_rx ", w}, int'(irq_rx), mr);
        chk({"R4 irq_tx ", w}, int'(irq_tx), mt);
        chk({"R8 irq_ovr ", w}, int'(irq_ovr), mo);
        chk({"R9 stat_msk ", w}, int'(stat_msk), mo * 4 + mt * 2 + mr);
        chk({"R9 irq_any ", w}, int'(irq_any), int'((mr | mt | mo) != 0));
    endtask

    // all mask combinations, port on and off, with no strobes active
    task automatic sweep(input string w);
        for (int m = 0; m < 8; m++) begin
            for (int e = 0; e < 2; e++) begin
                {mask_ovr, mask_tx, mask_rx} = 3'(m);
                port_en = e[0];
                #4;
                check_all(w);
            end
        end
        port_en = 1'b1;
        {mask_ovr, mask_tx, mask_rx} = 3'b111;
    endtask

    task automatic cyc(input bit twr, input int twd, input bit trd,
                       input bit rfr, input int rfd, input bit rrd, input bit clr);
        bit tpop, tpush, rpush, rpop, revent;
        if (trd && etx_q.size() > 0) chk("R1 tx order", int'(tx_rdata), etx_q[0]);
        if (rrd && erx_q.size() > 0) chk("R1 rx order", int'(rx_rdata), erx_q[0]);
        tpop   = trd && etx_q.size() > 0;
        tpush  = twr && (etx_q.size() < DEPTH || tpop);
        rpop   = rrd && erx_q.size() > 0;
        rpush  = rfr && port_en && (erx_q.size() < DEPTH || rpop);
        revent = rfr && port_en && erx_q.size() == DEPTH && !rrd;
        tx_wr = twr; tx_wdata = DW'(twd); tx_rd = trd;
        rx_frame = rfr; rx_frame_data = DW'(rfd); rx_rd = rrd; ovr_clr = clr;
        @(posedge clk);
        #1;
        tx_wr = 0; tx_rd = 0; rx_frame = 0; rx_rd = 0; ovr_clr = 0;
        if (tpop) void'(etx_q.pop_front());
        if (tpush) etx_q.push_back(twd & 255);
        if (rpop) void'(erx_q.pop_front());
        if (rpush) erx_q.push_back(rfd & 255);
        eovr = revent | (eovr & ~clr);
    endtask

    function automatic int nextval();
        seed = (seed * 37 + 11) % 251;
        return seed;
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int c0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R10 irq_any after reset", int'(irq_any), 0);
        chk("R10 stat_raw after reset", int'(stat_raw), 3'b010);
        chk("R10 counts after reset", int'(tx_count) + int'(rx_count), 0);
        check_all("reset");

        port_en = 1'b1;
        {mask_ovr, mask_tx, mask_rx} = 3'b111;

        // fill both FIFOs level by level
        sweep("level 0");
        for (int k = 1; k <= DEPTH; k++) begin
            cyc(1, nextval(), 0, 1, nextval(), 0, 0);
            sweep($sformatf("fill %0d", k));
        end

        // push into full transmit FIFO is ignored
        cyc(1, 99, 0, 0, 0, 0, 0);
        chk("R1 tx push while full ignored", int'(tx_count), DEPTH);
        check_all("tx full push");

        // overrun: frame while rx full, FIFO kept
        c0 = erx_q[0];
        cyc(0, 0, 0, 1, 77, 0, 0);
        chk("R5 overrun flag set", int'(stat_raw[2]), 1);
        chk("R5 head kept", int'(rx_rdata), c0);
        sweep("overrun");

        // clear and new overrun in the same cycle: set wins
        cyc(0, 0, 0, 1, 55, 0, 1);
        chk("R6 set beats clear", int'(stat_raw[2]), 1);
        // plain clear
        cyc(0, 0, 0, 0, 0, 0, 1);
        chk("R6 cleared by ovr_clr", int'(stat_raw[2]), 0);
        // stays clear without events
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk("R6 stays clear", int'(stat_raw[2]), 0);

        // full with simultaneous read: frame accepted, no overrun
        cyc(0, 0, 0, 1, 66, 1, 0);
        chk("R5 read with frame no overrun", int'(stat_raw[2]), 0);
        chk("R2 rx full push+pop count", int'(rx_count), DEPTH);
        cyc(1, 44, 1, 0, 0, 0, 0);
        chk("R2 tx full push+pop count", int'(tx_count), DEPTH);
        check_all("full push pop");

        // port disabled: frames ignored even when full
        port_en = 1'b0;
        cyc(0, 0, 0, 1, 33, 0, 0);
        chk("R7 no overrun while disabled", int'(stat_raw[2]), 0);
        cyc(0, 0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 1, 34, 0, 0);
        chk("R7 no push while disabled", int'(rx_count), DEPTH - 1);
        mask_tx = 1'b1;
        chk("R4 tx request ignores enable", int'(irq_tx), int'(etx_q.size() <= 4));
        port_en = 1'b1;

        // drain level by level
        for (int k = DEPTH - 1; k >= 0; k--) begin
            cyc(0, 0, 1, 0, 0, (erx_q.size() > 0), 0);
            sweep($sformatf("drain %0d", k));
        end
        while (erx_q.size() > 0) cyc(0, 0, 0, 0, 0, 1, 0);
        check_all("drained");

        // pop from empty is ignored
        cyc(0, 0, 1, 0, 0, 1, 0);
        chk("R1 tx pop empty", int'(tx_count), 0);
        chk("R1 rx pop empty", int'(rx_count), 0);
        // empty push+pop: push taken
        cyc(1, 12, 1, 1, 13, 1, 0);
        chk("R2 tx empty push+pop", int'(tx_count), 1);
        chk("R2 rx empty push+pop", int'(rx_count), 1);
        // middle level push+pop
        cyc(1, 21, 0, 1, 22, 0, 0);
        cyc(1, 23, 1, 1, 24, 1, 0);
        chk("R2 tx mid push+pop", int'(tx_count), 2);
        chk("R2 rx mid push+pop", int'(rx_count), 2);
        check_all("mid");
        for (int k = 0; k < 4; k++) cyc(1, 100 + k, 1, 1, 110 + k, 1, 0);
        while (etx_q.size() > 0 || erx_q.size() > 0)
            cyc(0, 0, etx_q.size() > 0, 0, 0, erx_q.size() > 0, 0);
        check_all("final");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule